// File: doc/BRIEF.md
# FM Modulation and Envelope Timebase

This block is the shared timebase of an FM synthesis voice engine. It is advanced by a single strobe once per output sample. From that strobe it derives four things: a slow triangular tremolo attenuation, a 3-bit vibrato position, the low two bits of the sample count, and a toggling envelope phase bit. It also produces an envelope rate base taken from a wide, half-rate envelope counter.

Envelope generators and phase generators across the chip read these outputs; they are not part of this block. Two depth inputs choose the tremolo attenuation scale and the vibrato shift that phase generators apply. Every output is a register that changes only on a cycle where the strobe is high.

Top module: `fm_mod_timer`

## Requirements
- R1: After reset, `trem_level`=0, `vib_pos`=0, `vib_shift`=1, `tmr_phase`=0, `eg_phase`=0 and `eg_step`=0.
- R2: On a clock edge where `tick` is low, no output changes.
- R3: A sample counter counts ticks. On a tick taken while its low 6 bits are all ones, the tremolo position (0..209) advances and wraps from 209 to 0. `trem_level` then shows the triangle of the new position: the position itself below 105, and 210 minus the position from 105 up. A full tremolo period is 13440 ticks.
- R4: The triangle is divided by 4 when `trem_deep`=1 and by 16 when `trem_deep`=0, using the depth value present on that tick.
- R5: On a tick taken while the sample counter's low 10 bits are all ones, `vib_pos` advances by one modulo 8.
- R6: On each tick, `vib_shift` becomes 0 if `vib_deep`=1 and 1 otherwise.
- R7: `tmr_phase` equals the number of ticks since reset, modulo 4.
- R8: `eg_phase` inverts on every tick.
- R9: On each tick, `eg_step` takes a value from the envelope timer as it stood before that tick. If the timer is zero, or has more than 12 trailing zero bits, the value is 0. Otherwise it is 1 plus the trailing-zero count.
- R10: On a tick, the envelope timer (reset 0) advances if the `eg_phase` value before that tick is 1 or a carry is pending. It holds otherwise.
- R11: When an advance finds the timer all ones, the timer becomes 0 and the carry is set. That makes the next tick advance the timer whatever `eg_phase` is. Any other advance clears the carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe, one cycle per sample |
| trem_deep | input | 1 | Tremolo depth select (1 = divide by 4) |
| vib_deep | input | 1 | Vibrato depth select (1 = shift 0) |
| trem_level | output | TREM_W (7) | Tremolo attenuation value |
| vib_pos | output | 3 | Vibrato position |
| vib_shift | output | 1 | Vibrato range shift |
| tmr_phase | output | 2 | Low two bits of the sample count |
| eg_phase | output | 1 | Alternating envelope phase bit |
| eg_step | output | 4 | Envelope rate base (0..13) |

## Verification
The first pattern is an unbroken run of strobes with both depth bits low. It covers more than a full tremolo period and all eight vibrato steps, so it checks the step points at 64 and 1024 ticks and the triangle turning point at 105. A second run with both depth bits high checks the divide-by-4 scale and the zero vibrato shift. A third pattern puts gaps in the strobe and toggles the depth bits mid-run, which separates tick-driven updates from clock-driven ones. That run lasts long enough for the envelope timer to pass 8192, so a 13-zero value that yields a zero step is covered. A second copy of the block with a 4-bit envelope timer wraps many times, which exposes the carry that forces an advance on an even tick.

// File: rtl/fm_mod_pkg.sv
package fm_mod_pkg;
  localparam int TREM_STEPS = 210;
  localparam int TREM_HALF  = TREM_STEPS / 2;
  localparam int TPOS_W     = $clog2(TREM_STEPS);
  localparam int TREM_EVT_BITS = 6;
  localparam int VIB_EVT_BITS  = 10;
  localparam int EG_TZ_LIMIT   = 12;

  // Triangle fold of a tremolo position
  function automatic logic [TPOS_W-1:0] trem_fold(input logic [TPOS_W-1:0] pos);
    if (int'(pos) < TREM_HALF) return pos;
    return TPOS_W'(TREM_STEPS) - pos;
  endfunction

  // Attenuation shift chosen by the depth bit
  function automatic int trem_shift(input logic deep);
    return deep ? 2 : 4;
  endfunction
endpackage

// File: rtl/fm_mod_trem.sv
module fm_mod_trem
  import fm_mod_pkg::*;
#(
  parameter int TREM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              step_evt,
  input  logic              deep,
  output logic [TREM_W-1:0] level
);
  logic [TPOS_W-1:0] pos_q, pos_nxt;
  logic              pos_wrap;
  logic [TPOS_W-1:0] fold;

  assign pos_wrap = step_evt && (int'(pos_q) == TREM_STEPS - 1);

  always_comb begin
    pos_nxt = pos_q;
    if (step_evt) pos_nxt = pos_wrap ? '0 : pos_q + 1'b1;
  end

  assign fold = trem_fold(pos_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      level <= '0;
    end else if (tick) begin
      pos_q <= pos_nxt;
      level <= TREM_W'(fold >> trem_shift(deep));
    end
  end

  AST_TPOS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos_q) < TREM_STEPS); // R3
  AST_TPOS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && pos_wrap |=> pos_q == '0); // R3
  AST_TREM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(level) <= (TREM_HALF >> 2)); // R4
endmodule

// File: rtl/fm_mod_vib.sv
module fm_mod_vib (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       step_evt,
  input  logic       deep,
  output logic [2:0] pos,
  output logic       shift
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      shift <= 1'b1;
    end else if (tick) begin
      if (step_evt) pos <= pos + 3'd1;
      shift <= ~deep;
    end
  end

  AST_VIB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && step_evt |=> pos == 3'($past(pos) + 3'd1)); // R5
  AST_VIB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> shift == !$past(deep)); // R6
endmodule

// File: rtl/fm_mod_egtimer.sv
module fm_mod_egtimer
  import fm_mod_pkg::*;
#(
  parameter int EGT_W = 36
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  output logic       phase,
  output logic [3:0] step
);
  logic [EGT_W-1:0] timer_q;
  logic             carry_q;
  logic             inc_en;
  logic             wrap_evt;
  int               tz;
  logic [3:0]       step_nxt;

  assign inc_en   = phase | carry_q;
  assign wrap_evt = inc_en & (&timer_q);

  // Lowest set bit index of the timer
  always_comb begin
    tz = EGT_W;
    for (int i = EGT_W - 1; i >= 0; i--) begin
      if (timer_q[i]) tz = i;
    end
  end

  assign step_nxt = (timer_q == '0 || tz > EG_TZ_LIMIT) ? 4'd0 : 4'(tz + 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer_q <= '0;
      carry_q <= 1'b0;
      phase   <= 1'b0;
      step    <= '0;
    end else if (tick) begin
      step  <= step_nxt;
      phase <= ~phase;
      if (inc_en) begin
        timer_q <= wrap_evt ? '0 : timer_q + 1'b1;
        carry_q <= wrap_evt;
      end
    end
  end

  AST_EG_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && wrap_evt |=> timer_q == '0 && carry_q); // R11
  AST_EG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !inc_en |=> $stable(timer_q)); // R10
  AST_EG_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> phase != $past(phase)); // R8
  AST_EG_STEP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    step <= 4'(EG_TZ_LIMIT + 1)); // R9
endmodule

// File: rtl/fm_mod_timer.sv
module fm_mod_timer
  import fm_mod_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int EGT_W  = 36,
  parameter int TREM_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trem_deep,
  input  logic              vib_deep,
  output logic [TREM_W-1:0] trem_level,
  output logic [2:0]        vib_pos,
  output logic              vib_shift,
  output logic [1:0]        tmr_phase,
  output logic              eg_phase,
  output logic [3:0]        eg_step
);
  localparam int CW = (CNT_W < VIB_EVT_BITS) ? VIB_EVT_BITS : CNT_W;

  logic [CW-1:0] cnt_q;
  logic          trem_evt;
  logic          vib_evt;

  assign trem_evt  = &cnt_q[TREM_EVT_BITS-1:0];
  assign vib_evt   = &cnt_q[VIB_EVT_BITS-1:0];
  assign tmr_phase = cnt_q[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  fm_mod_trem #(.TREM_W(TREM_W)) u_trem (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_evt(trem_evt),
    .deep(trem_deep), .level(trem_level)
  );

  fm_mod_vib u_vib (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_evt(vib_evt),
    .deep(vib_deep), .pos(vib_pos), .shift(vib_shift)
  );

  fm_mod_egtimer #(.EGT_W(EGT_W)) u_eg (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(eg_phase), .step(eg_step)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(trem_level) && $stable(vib_pos) && $stable(vib_shift)
              && $stable(tmr_phase) && $stable(eg_phase) && $stable(eg_step)); // R2
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> tmr_phase == 2'($past(tmr_phase) + 2'd1)); // R7
endmodule

// File: tb/fm_mod_timer_tb.sv
module fm_mod_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic trem_deep = 1'b0;
  logic vib_deep = 1'b0;
  logic [6:0] trem_level;
  logic [2:0] vib_pos;
  logic       vib_shift;
  logic [1:0] tmr_phase;
  logic       eg_phase;
  logic [3:0] eg_step;
  logic [6:0] s_level;
  logic [2:0] s_vpos;
  logic       s_vsh, s_eph;
  logic [1:0] s_tph;
  logic [3:0] s_step;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  fm_mod_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trem_deep(trem_deep), .vib_deep(vib_deep),
    .trem_level(trem_level), .vib_pos(vib_pos), .vib_shift(vib_shift),
    .tmr_phase(tmr_phase), .eg_phase(eg_phase), .eg_step(eg_step)
  );

  fm_mod_timer #(.EGT_W(4)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trem_deep(trem_deep), .vib_deep(vib_deep),
    .trem_level(s_level), .vib_pos(s_vpos), .vib_shift(s_vsh),
    .tmr_phase(s_tph), .eg_phase(s_eph), .eg_step(s_step)
  );

  // Reference model
  int          m_cnt, m_tpos, m_level, m_vpos, m_vsh;
  logic [35:0] m_timer [2];
  logic [35:0] m_full  [2];
  logic        m_carry [2];
  logic        m_state [2];
  int          m_step  [2];

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, m_cnt);
    end
  endtask

  function automatic int step_of(input logic [35:0] t);
    int z;
    if (t == 0) return 0;
    z = 0;
    while (t[z] == 1'b0) z++;
    return (z > 12) ? 0 : z + 1;
  endfunction

  task automatic model_tick(input logic td, input logic vd);
    int fold;
    if (m_cnt % 64 == 63) m_tpos = (m_tpos + 1) % 210;
    fold = (m_tpos < 105) ? m_tpos : 210 - m_tpos;
    m_level = td ? fold / 4 : fold / 16;
    if (m_cnt % 1024 == 1023) m_vpos = (m_vpos + 1) % 8;
    m_vsh = vd ? 0 : 1;
    m_cnt++;
    for (int k = 0; k < 2; k++) begin
      m_step[k] = step_of(m_timer[k]);
      if (m_state[k] || m_carry[k]) begin
        if (m_timer[k] == m_full[k]) begin
          m_timer[k] = 0;
          m_carry[k] = 1'b1;
        end else begin
          m_timer[k] = m_timer[k] + 1;
          m_carry[k] = 1'b0;
        end
      end
      m_state[k] = ~m_state[k];
    end
  endtask

  task automatic check_all();
    chk("R3 R4 trem_level", trem_level, m_level);
    chk("R5 vib_pos", vib_pos, m_vpos);
    chk("R6 vib_shift", vib_shift, m_vsh);
    chk("R7 tmr_phase", tmr_phase, m_cnt % 4);
    chk("R8 eg_phase", eg_phase, m_state[0]);
    chk("R9 eg_step", eg_step, m_step[0]);
    chk("R10 R11 eg_step small timer", s_step, m_step[1]);
  endtask

  logic applied, ap_td, ap_vd;
  logic [6:0] prev_level;
  logic [3:0] prev_step;

  task automatic run(input int cycles, input int mode);
    logic nt, ntd, nvd;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (applied) model_tick(ap_td, ap_vd);
      else begin
        chk("R2 level held", trem_level, prev_level);
        chk("R2 eg_step held", eg_step, prev_step);
      end
      check_all();
      prev_level = trem_level;
      prev_step  = eg_step;
      case (mode)
        0: begin nt = 1'b1; ntd = 1'b0; nvd = 1'b0; end
        1: begin nt = 1'b1; ntd = 1'b1; nvd = 1'b1; end
        default: begin
          nt  = (c % 3) != 0;
          ntd = ((c / 700) % 2) == 1;
          nvd = ((c / 500) % 2) == 0;
        end
      endcase
      tick = nt; trem_deep = ntd; vib_deep = nvd;
      applied = nt; ap_td = ntd; ap_vd = nvd;
    end
  endtask

  initial begin
    #(20ns * 250000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    m_cnt = 0; m_tpos = 0; m_level = 0; m_vpos = 0; m_vsh = 1;
    m_full[0] = 36'hF_FFFF_FFFF;
    m_full[1] = 36'hF;
    for (int k = 0; k < 2; k++) begin
      m_timer[k] = 0; m_carry[k] = 0; m_state[k] = 0; m_step[k] = 0;
    end
    applied = 1'b0; ap_td = 1'b0; ap_vd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 trem_level", trem_level, 0);
    chk("R1 vib_pos", vib_pos, 0);
    chk("R1 vib_shift", vib_shift, 1);
    chk("R1 tmr_phase", tmr_phase, 0);
    chk("R1 eg_phase", eg_phase, 0);
    chk("R1 eg_step", eg_step, 0);
    prev_level = trem_level;
    prev_step  = eg_step;
    run(13500, 0);
    // R3: one full period returned the position to the start region
    chk("R3 period position", m_tpos, 0);
    run(3000, 1);
    run(9000, 2);
    chk("R9 timer passed 8192", (m_timer[0] >= 8192) ? 1 : 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule